// File: doc/BRIEF.md
# Associative Address Translation Cache with Access Checks

This block caches recently used page table entries so that a virtual address can be turned into a physical address without a walk through memory. Each slot holds a virtual page number as its tag and a full page table entry as its data. A lookup compares the page number of the request against every slot at once. A matching slot yields the physical address in the same cycle, built from the stored frame number and the untouched page offset.

A matching slot is not always a usable one. The stored entry's valid flag and its two-bit access field decide whether the requested kind of access (data read, data write or instruction fetch) may proceed. A forbidden access is reported as a fault rather than a hit. A permitted access sets the stored referenced flag, and a permitted write also sets the dirty flag.

A lookup that matches no slot raises a miss and records the page number for an external refill agent. That agent later writes an entry through the fill port. The fill goes into a free slot, or into the slot already holding the same page, or else into the least recently used slot. Software keeps the cache coherent by invalidating one page after changing its rights, or by flushing every slot on a context switch.

Top module: `tlbx_top`

## Requirements
- R1: A lookup compares the virtual page number (address bits above the 12-bit offset) against all occupied slots, whichever slot holds the page; a permitted match drives rsp_hit high and rsp_pa = {frame number, offset} combinationally in the same cycle.
- R2: A fill writes fill_pte, laid out as bit 24 valid, bit 23 referenced, bit 22 dirty, bits 21:20 access field, bits 19:0 frame number, together with the tag fill_vpn.
- R3: req_kind 0 is a data read, 1 a data write, 2 an instruction fetch, and 3 always faults. The access field is 0 no access, 1 read only, 2 read and write, 3 fetch only. A matched entry whose valid bit is 0, or whose access field forbids the kind, gives rsp_fault high and rsp_hit low.
- R4: rsp_ref and rsp_mod show the matched entry's stored flags before the current access. A permitted access sets referenced from the next cycle on, and dirty is set only by a permitted write.
- R5: A faulting lookup leaves the stored flags and the replacement order unchanged.
- R6: A lookup with no match drives rsp_miss high in the same cycle. From the next cycle miss_pend is high and miss_vpn holds that page, until a fill or a flush clears it.
- R7: A fill whose page is already resident overwrites that slot, so later lookups see only the new entry.
- R8: inval_valid with inval_vpn removes only the slot holding that page; other slots keep translating.
- R9: flush_i empties every slot and clears miss_pend from the next cycle.
- R10: A fill of a new page takes the lowest-numbered free slot. When none is free it replaces the slot whose last hit or fill lies furthest back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_va | input | 32 | Virtual address |
| rsp_hit | output | 1 | Permitted translation |
| rsp_fault | output | 1 | Match but access forbidden or entry invalid |
| rsp_miss | output | 1 | No slot matches |
| rsp_pa | output | 32 | Physical address |
| rsp_ref | output | 1 | Stored referenced flag of matched entry |
| rsp_mod | output | 1 | Stored dirty flag of matched entry |
| miss_pend | output | 1 | A miss awaits refill |
| miss_vpn | output | 20 | Page number of the pending miss |
| fill_valid | input | 1 | Write an entry |
| fill_vpn | input | 20 | Tag for the fill |
| fill_pte | input | 25 | Page table entry for the fill |
| inval_valid | input | 1 | Invalidate one page |
| inval_vpn | input | 20 | Page to invalidate |
| flush_i | input | 1 | Empty all slots |

## Verification
The hardest situation to reach is replacement in a full cache, where the victim depends on the whole history of hits and fills. The stimulus flushes the cache and fills every slot in a known order. It then touches the oldest page so that the second oldest becomes the victim. One more fill follows, and lookups then show which page was displaced and which survived. Flag updates are brought out through rsp_ref and rsp_mod on repeated lookups of the same page, including after a faulting write that must not touch them.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int PFN_W = 20;
    localparam int OFF_W = 12;

    typedef enum logic [1:0] {
        PROT_NONE = 2'd0,
        PROT_RO   = 2'd1,
        PROT_RW   = 2'd2,
        PROT_XO   = 2'd3
    } prot_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic              refd;
        logic              dirty;
        prot_e             prot;
        logic [PFN_W-1:0]  pfn;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    function automatic logic access_ok(pte_t p, acc_e k);
        logic ok;
        case (k)
            ACC_READ:  ok = (p.prot == PROT_RO) || (p.prot == PROT_RW);
            ACC_WRITE: ok = (p.prot == PROT_RW);
            ACC_FETCH: ok = (p.prot == PROT_XO);
            default:   ok = 1'b0;
        endcase
        return ok && p.valid;
    endfunction

endpackage

// File: rtl/tlbx_match.sv
module tlbx_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES-1:0]            occ,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = occ[g] && (tags[g] == key);
    end
endmodule

// File: rtl/tlbx_lru.sv
module tlbx_lru #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);
    typedef struct packed {
        logic [ENTRIES-1:0][IDX_W-1:0] age;
    } lru_t;

    lru_t s_d, s_q;
    logic [ENTRIES-1:0] oldest;

    always_comb begin
        s_d = s_q;
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            oldest[i] = (s_q.age[i] == IDX_W'(ENTRIES - 1));
            if (oldest[i]) victim_idx = IDX_W'(i);
            if (touch) begin
                if (IDX_W'(i) == touch_idx) s_d.age[i] = '0;
                else if (s_q.age[i] < s_q.age[touch_idx]) s_d.age[i] = s_q.age[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) s_q.age[i] <= IDX_W'(i);
        end else begin
            s_q <= s_d;
        end
    end

    // Ages stay a permutation, so exactly one slot is the victim.
    p_one_oldest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);

endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [VA_W-1:0]  req_va,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic             rsp_miss,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_ref,
    output logic             rsp_mod,
    output logic             miss_pend,
    output logic [VPN_W-1:0] miss_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PTE_W-1:0] fill_pte,
    input  logic             inval_valid,
    input  logic [VPN_W-1:0] inval_vpn,
    input  logic             flush_i
);
    typedef struct packed {
        logic [ENTRIES-1:0]            occ;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        pte_t [ENTRIES-1:0]            pte;
        logic                          miss_pend;
        logic [VPN_W-1:0]              miss_vpn;
    } state_t;

    state_t q, d;

    logic [VPN_W-1:0]   vpn;
    logic [OFF_W-1:0]   off;
    logic [ENTRIES-1:0] look_vec, fill_vec, inv_vec;
    logic [IDX_W-1:0]   look_idx, fill_idx, inv_idx, free_idx, lru_idx, wr_idx;
    logic               look_any, fill_any, inv_any, free_any, perm;
    logic               touch;
    logic [IDX_W-1:0]   touch_idx;
    pte_t               cur;

    assign vpn = req_va[VA_W-1:OFF_W];
    assign off = req_va[OFF_W-1:0];

    tlbx_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_look (
        .occ(q.occ), .tags(q.tag), .key(vpn),       .hit_vec(look_vec));
    tlbx_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_fillm (
        .occ(q.occ), .tags(q.tag), .key(fill_vpn),  .hit_vec(fill_vec));
    tlbx_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_invm (
        .occ(q.occ), .tags(q.tag), .key(inval_vpn), .hit_vec(inv_vec));

    tlbx_lru #(.ENTRIES(ENTRIES)) i_lru (
        .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
        .victim_idx(lru_idx));

    // Encoders and free-slot search
    always_comb begin
        look_idx = '0; fill_idx = '0; inv_idx = '0; free_idx = '0; free_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (look_vec[i]) look_idx = IDX_W'(i);
            if (fill_vec[i]) fill_idx = IDX_W'(i);
            if (inv_vec[i])  inv_idx  = IDX_W'(i);
            if (!q.occ[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
        look_any = |look_vec;
        fill_any = |fill_vec;
        inv_any  = |inv_vec;
        wr_idx   = fill_any ? fill_idx : (free_any ? free_idx : lru_idx);
    end

    // Lookup response and next state
    always_comb begin
        cur       = q.pte[look_idx];
        perm      = access_ok(cur, acc_e'(req_kind));
        rsp_hit   = req_valid && look_any && perm;
        rsp_fault = req_valid && look_any && !perm;
        rsp_miss  = req_valid && !look_any;
        rsp_pa    = {cur.pfn, off};
        rsp_ref   = cur.refd;
        rsp_mod   = cur.dirty;

        d = q;
        if (rsp_hit) begin
            d.pte[look_idx].refd = 1'b1;
            if (acc_e'(req_kind) == ACC_WRITE) d.pte[look_idx].dirty = 1'b1;
        end
        if (fill_valid) begin
            d.occ[wr_idx] = 1'b1;
            d.tag[wr_idx] = fill_vpn;
            d.pte[wr_idx] = pte_t'(fill_pte);
            d.miss_pend   = 1'b0;
        end
        if (rsp_miss) begin
            d.miss_pend = 1'b1;
            d.miss_vpn  = vpn;
        end
        if (inval_valid && inv_any) d.occ[inv_idx] = 1'b0;
        if (flush_i) begin
            d.occ       = '0;
            d.miss_pend = 1'b0;
        end

        touch     = fill_valid || rsp_hit;
        touch_idx = fill_valid ? wr_idx : look_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign miss_pend = q.miss_pend;
    assign miss_vpn  = q.miss_vpn;

    // Fills never leave two slots holding one page.
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_vec));

    p_dirty_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && req_kind == 2'd1 && !fill_valid && !inval_valid && !flush_i)
        |=> q.pte[$past(look_idx)].dirty && q.pte[$past(look_idx)].refd);

    p_fault_keeps_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && !fill_valid && !flush_i) |=> $stable(q.pte));

    p_miss_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss && !flush_i) |=> (miss_pend && miss_vpn == $past(vpn)));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (q.occ == '0 && !miss_pend));

endmodule

// File: tb/test_tlbx_top.sv
module test_tlbx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_va = '0;
    logic        rsp_hit, rsp_fault, rsp_miss, rsp_ref, rsp_mod, miss_pend;
    logic [31:0] rsp_pa;
    logic [19:0] miss_vpn;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [24:0] fill_pte = '0;
    logic        inval_valid = 1'b0;
    logic [19:0] inval_vpn = '0;
    logic        flush_i = 1'b0;

    int checks = 0;
    int failures = 0;
    logic o_hit, o_fault, o_miss, o_ref, o_mod;
    logic [31:0] o_pa;

    always #4 clk = ~clk;

    tlbx_top i_tlbx_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_va(req_va), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_miss(rsp_miss), .rsp_pa(rsp_pa), .rsp_ref(rsp_ref),
        .rsp_mod(rsp_mod), .miss_pend(miss_pend), .miss_vpn(miss_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
        .inval_valid(inval_valid), .inval_vpn(inval_vpn), .flush_i(flush_i));

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] va;
        logic        hit;
        logic        fault;
        logic        miss;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h00010ABC, 1'b1, 1'b0, 1'b0, 32'hAAAAAABC},  // R1 read RW
        '{2'd1, 32'h00010004, 1'b1, 1'b0, 1'b0, 32'hAAAAA004},  // R3 write RW
        '{2'd2, 32'h00010000, 1'b0, 1'b1, 1'b0, 32'hAAAAA000},  // R3 fetch RW
        '{2'd0, 32'h00020FFF, 1'b1, 1'b0, 1'b0, 32'h12345FFF},  // R1 read RO
        '{2'd1, 32'h00020000, 1'b0, 1'b1, 1'b0, 32'h12345000},  // R3 write RO
        '{2'd2, 32'h00030010, 1'b1, 1'b0, 1'b0, 32'h00777010},  // R3 fetch XO
        '{2'd0, 32'h00030010, 1'b0, 1'b1, 1'b0, 32'h00777010},  // R3 read XO
        '{2'd0, 32'h00040000, 1'b0, 1'b1, 1'b0, 32'h00001000},  // R3 none
        '{2'd1, 32'h00040000, 1'b0, 1'b1, 1'b0, 32'h00001000},  // R3 none
        '{2'd0, 32'h00050000, 1'b0, 1'b1, 1'b0, 32'h00002000},  // R3 invalid
        '{2'd3, 32'h00010000, 1'b0, 1'b1, 1'b0, 32'hAAAAA000},  // R3 reserved kind
        '{2'd0, 32'h00099123, 1'b0, 1'b0, 1'b1, 32'h00000000}   // R6 miss
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [1:0] k, input logic [31:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_va = va;
        #2;
        o_hit = rsp_hit; o_fault = rsp_fault; o_miss = rsp_miss;
        o_pa = rsp_pa; o_ref = rsp_ref; o_mod = rsp_mod;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    function automatic logic [24:0] mk_pte(logic v, logic r, logic m, logic [1:0] p, logic [19:0] f);
        return {v, r, m, p, f};
    endfunction

    task automatic fill(input logic [19:0] vp, input logic [24:0] pte);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vp; fill_pte = pte;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    task automatic inval(input logic [19:0] vp);
        @(negedge clk);
        inval_valid = 1'b1; inval_vpn = vp;
        @(posedge clk); #1;
        inval_valid = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(posedge clk); #1;
        flush_i = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        chk("R6 reset miss_pend", 64'(miss_pend), 64'd0);
        lookup(2'd0, 32'h00010000);
        chk("R1 empty after reset misses", 64'(o_miss), 64'd1);
        flush();

        // Setup entries
        fill(20'h00010, mk_pte(1, 0, 0, 2'd2, 20'hAAAAA));
        fill(20'h00020, mk_pte(1, 0, 0, 2'd1, 20'h12345));
        fill(20'h00030, mk_pte(1, 0, 0, 2'd3, 20'h00777));
        fill(20'h00040, mk_pte(1, 0, 0, 2'd0, 20'h00001));
        fill(20'h00050, mk_pte(0, 0, 0, 2'd2, 20'h00002));

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].kind, VECS[i].va);
            chk($sformatf("R1/R3 vec%0d hit", i),   64'(o_hit),   64'(VECS[i].hit));
            chk($sformatf("R3 vec%0d fault", i),    64'(o_fault), 64'(VECS[i].fault));
            chk($sformatf("R6 vec%0d miss", i),     64'(o_miss),  64'(VECS[i].miss));
            if (VECS[i].hit) chk($sformatf("R1 R2 vec%0d pa", i), 64'(o_pa), 64'(VECS[i].pa));
        end

        // R6 latched miss and clear by fill
        chk("R6 miss_pend set", 64'(miss_pend), 64'd1);
        chk("R6 miss_vpn", 64'(miss_vpn), 64'h00099);
        fill(20'h00099, mk_pte(1, 0, 0, 2'd2, 20'h0BEEF));
        chk("R6 fill clears miss_pend", 64'(miss_pend), 64'd0);
        lookup(2'd0, 32'h00099123);
        chk("R6 refilled page hits", 64'(o_pa), 64'h0BEEF123);

        // R4 referenced and dirty flags
        fill(20'h00060, mk_pte(1, 0, 0, 2'd2, 20'h00600));
        lookup(2'd0, 32'h00060000);
        chk("R4 ref clear before first use", 64'(o_ref), 64'd0);
        lookup(2'd0, 32'h00060000);
        chk("R4 ref set after read", 64'(o_ref), 64'd1);
        chk("R4 dirty clear after read", 64'(o_mod), 64'd0);
        lookup(2'd1, 32'h00060000);
        chk("R4 dirty before write", 64'(o_mod), 64'd0);
        lookup(2'd0, 32'h00060000);
        chk("R4 dirty after write", 64'(o_mod), 64'd1);

        // R5 faulting access leaves flags alone
        fill(20'h00070, mk_pte(1, 0, 0, 2'd1, 20'h00700));
        lookup(2'd1, 32'h00070000);
        chk("R5 write to read-only faults", 64'(o_fault), 64'd1);
        lookup(2'd0, 32'h00070000);
        chk("R5 ref untouched by fault", 64'(o_ref), 64'd0);
        chk("R5 dirty untouched by fault", 64'(o_mod), 64'd0);

        // R2 stored flags come from fill word
        fill(20'h00080, mk_pte(1, 1, 1, 2'd2, 20'h00800));
        lookup(2'd0, 32'h00080000);
        chk("R2 fill ref bit", 64'(o_ref), 64'd1);
        chk("R2 fill dirty bit", 64'(o_mod), 64'd1);

        // R7 overwrite of resident page
        fill(20'h00010, mk_pte(1, 0, 0, 2'd1, 20'h55555));
        lookup(2'd0, 32'h00010321);
        chk("R7 overwrite pa", 64'(o_pa), 64'h55555321);
        lookup(2'd1, 32'h00010321);
        chk("R7 overwrite rights", 64'(o_fault), 64'd1);

        // R8 single invalidate
        inval(20'h00020);
        lookup(2'd0, 32'h00020000);
        chk("R8 invalidated page misses", 64'(o_miss), 64'd1);
        lookup(2'd2, 32'h00030000);
        chk("R8 other page survives", 64'(o_hit), 64'd1);

        // R9 flush
        lookup(2'd0, 32'h00123000);
        flush();
        chk("R9 flush clears miss_pend", 64'(miss_pend), 64'd0);
        lookup(2'd2, 32'h00030000);
        chk("R9 flushed page misses", 64'(o_miss), 64'd1);

        // R10 replacement order
        flush();
        for (int i = 0; i < 16; i++)
            fill(20'h00100 + 20'(i), mk_pte(1, 0, 0, 2'd2, 20'(i)));
        lookup(2'd0, 32'h00100000);
        chk("R10 first slot hit", 64'(o_pa), 64'h00000000);
        fill(20'h00200, mk_pte(1, 0, 0, 2'd2, 20'h00EEE));
        lookup(2'd0, 32'h00101000);
        chk("R10 oldest page evicted", 64'(o_miss), 64'd1);
        lookup(2'd0, 32'h00100000);
        chk("R10 touched page kept", 64'(o_hit), 64'd1);
        lookup(2'd0, 32'h00200abc);
        chk("R10 new page hits", 64'(o_pa), 64'h00EEEABC);
        lookup(2'd0, 32'h00102000);
        chk("R10 next oldest kept", 64'(o_pa), 64'h00002000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule